// File: doc/BRIEF.md
# Triggered Binary Latency Pipeline with Event Queue

This block records one hit bit per channel on every clock into a circular column memory. Its depth can be set at run time, up to a fixed maximum. The write column moves forward by one each clock and wraps at the programmed depth. The memory therefore always holds the most recent `depth` cycles of hit data.

When a trigger arrives, the block works out which column was written a programmed number of cycles earlier and puts that column's address into a small event queue. That column stays protected from overwrite until the readout side takes it. The readout side drains the queue one event at a time through a valid/ready handshake. It receives the column address and the stored hit vector of that column.

Triggers can come in bursts faster than the readout can drain them, and the queue absorbs the bursts. A trigger that finds the queue full is lost, and a sticky flag records the loss.

Top module: `lat_pipe_top`

## Requirements
- R1: A synchronous active-high reset sets the write column to 0, empties the event queue (`evt_valid_o` low) and clears `ovf_o`.
- R2: On every clock `hit_i` is stored in the current write column. The column then advances by one and wraps from `cfg_depth_i - 1` to 0. `cfg_depth_i` lies in 1..DEPTH_MAX and is changed only during reset.
- R3: A trigger in a cycle whose write column is W queues column (W - `cfg_lat_i`) mod `cfg_depth_i`, with `cfg_lat_i` < `cfg_depth_i`. With latency 0 the queued column is the one written on that same edge. For the head event, `evt_data_o` is the hit vector stored in that column.
- R4: When the latency exceeds the write column, the queued column wraps to W + `cfg_depth_i` - `cfg_lat_i`.
- R5: `evt_valid_o` is high whenever the queue is not empty. An event is removed on a clock where `evt_valid_o` and `evt_ready_i` are both high. Events leave in trigger order.
- R6: A column held in the queue is not written, so its data survives any number of wraps. Columns not in the queue are overwritten as usual.
- R7: The queue holds DER_DEPTH (16) events. A trigger that finds 16 events held is dropped, even if a pop happens on the same edge, and `ovf_o` is set. `ovf_o` stays set until reset.
- R8: While `evt_valid_o` is high and `evt_ready_i` is low, `evt_valid_o`, `evt_addr_o` and `evt_data_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_i | input | NCH | Hit bits of this cycle, one per channel |
| trig_i | input | 1 | Trigger for the column written `cfg_lat_i` cycles earlier |
| cfg_depth_i | input | AW | Programmed ring depth (1..DEPTH_MAX) |
| cfg_lat_i | input | AW | Programmed trigger latency (< depth) |
| evt_valid_o | output | 1 | Queue holds at least one event |
| evt_ready_i | input | 1 | Readout accepts the head event |
| evt_addr_o | output | AW | Column address of the head event |
| evt_data_o | output | NCH | Stored hit vector of the head event column |
| ovf_o | output | 1 | Sticky: a trigger was dropped on a full queue |

## Verification
Each cycle drives a distinct hit pattern computed from the cycle number. A wrong column, an off-by-one latency or a stale overwrite therefore shows up as a data mismatch as well as an address mismatch. The latency is tried at zero, at a mid value without wrap, and at a value larger than the write column on a short ring. Together these separate same-edge capture, plain subtraction and modular wrap. A long stall with the ready input low, spanning several ring wraps, shows that a queued column keeps its data while an unqueued column is refreshed. A 17-trigger burst then confirms the queue capacity, the trigger order of release, and the sticky flag surviving the drain until reset.

// File: rtl/lat_pipe_pkg.sv
package lat_pipe_pkg;
    localparam int unsigned NCH_DEF       = 128;
    localparam int unsigned DEPTH_MAX_DEF = 160;
    localparam int unsigned DER_DEPTH_DEF = 16;
endpackage

// File: rtl/lat_wptr.sv
module lat_wptr #(
    parameter int unsigned DEPTH_MAX = 160,
    parameter int unsigned AW        = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_depth_i,
    input  logic [AW-1:0] cfg_lat_i,
    output logic [AW-1:0] wcol_o,
    output logic [AW-1:0] trig_col_o
);
    typedef struct packed {
        logic [AW-1:0] wcol;
    } wp_state_t;

    wp_state_t st_d, st_q;
    logic [AW-1:0] wcol_inc;

    always_comb begin
        st_d     = st_q;
        wcol_inc = st_q.wcol + AW'(1);
        if (wcol_inc >= cfg_depth_i) st_d.wcol = '0;
        else                         st_d.wcol = wcol_inc;
        if (rst) st_d.wcol = '0;
        // subtract modulo depth without overflowing AW bits
        if (st_q.wcol >= cfg_lat_i) trig_col_o = st_q.wcol - cfg_lat_i;
        else                        trig_col_o = (cfg_depth_i - cfg_lat_i) + st_q.wcol;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wcol_o = st_q.wcol;

    // R2
    wp_range_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(cfg_depth_i) |-> (st_q.wcol < cfg_depth_i));

    // R4
    trig_col_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_lat_i < cfg_depth_i && st_q.wcol < cfg_depth_i) |-> (trig_col_o < cfg_depth_i));
endmodule

// File: rtl/lat_colmem.sv
module lat_colmem #(
    parameter int unsigned NCH       = 128,
    parameter int unsigned DEPTH_MAX = 160,
    parameter int unsigned AW        = 8
) (
    input  logic           clk,
    input  logic           we_i,
    input  logic [AW-1:0]  waddr_i,
    input  logic [NCH-1:0] wdata_i,
    input  logic [AW-1:0]  raddr_i,
    output logic [NCH-1:0] rdata_o
);
    // storage array is registered directly; a next-state copy would double it
    logic [NCH-1:0] cols_q [DEPTH_MAX];

    always_ff @(posedge clk) begin
        if (we_i) cols_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = cols_q[raddr_i];
endmodule

// File: rtl/lat_derand.sv
module lat_derand #(
    parameter int unsigned DER_DEPTH = 16,
    parameter int unsigned AW        = 8,
    localparam int unsigned FW       = $clog2(DER_DEPTH),
    localparam int unsigned CW       = FW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic [AW-1:0] push_col_i,
    input  logic          ready_i,
    input  logic [AW-1:0] wcol_i,
    output logic          valid_o,
    output logic [AW-1:0] head_col_o,
    output logic          protect_o,
    output logic          ovf_o
);
    typedef struct packed {
        logic [DER_DEPTH-1:0][AW-1:0] slot;
        logic [FW-1:0]                head;
        logic [FW-1:0]                tail;
        logic [CW-1:0]                count;
        logic                         ovf;
    } dq_state_t;

    dq_state_t st_d, st_q;
    logic full, pop, take;
    logic [DER_DEPTH-1:0] hit_slot;

    always_comb begin
        full = (st_q.count == CW'(DER_DEPTH));
        pop  = ready_i && (st_q.count != '0);
        take = push_i && !full;

        for (int i = 0; i < DER_DEPTH; i++) begin
            hit_slot[i] = ({1'b0, FW'(FW'(i) - st_q.head)} < st_q.count)
                          && (st_q.slot[i] == wcol_i);
        end

        st_d = st_q;
        if (take) begin
            st_d.slot[st_q.tail] = push_col_i;
            st_d.tail            = st_q.tail + FW'(1);
        end
        if (pop) st_d.head = st_q.head + FW'(1);
        st_d.count = st_q.count + CW'(take) - CW'(pop);
        if (push_i && full) st_d.ovf = 1'b1;

        if (rst) begin
            st_d.head  = '0;
            st_d.tail  = '0;
            st_d.count = '0;
            st_d.ovf   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign valid_o    = (st_q.count != '0);
    assign head_col_o = st_q.slot[st_q.head];
    assign protect_o  = |hit_slot;
    assign ovf_o      = st_q.ovf;

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && full && !ready_i) |=> (st_q.count == CW'(DER_DEPTH)) && ovf_o);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ready_i) |=> (valid_o && $stable(head_col_o)));
endmodule

// File: rtl/lat_pipe_top.sv
module lat_pipe_top
    import lat_pipe_pkg::*;
#(
    parameter int unsigned NCH       = NCH_DEF,
    parameter int unsigned DEPTH_MAX = DEPTH_MAX_DEF,
    parameter int unsigned DER_DEPTH = DER_DEPTH_DEF,
    localparam int unsigned AW       = $clog2(DEPTH_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] hit_i,
    input  logic           trig_i,
    input  logic [AW-1:0]  cfg_depth_i,
    input  logic [AW-1:0]  cfg_lat_i,
    output logic           evt_valid_o,
    input  logic           evt_ready_i,
    output logic [AW-1:0]  evt_addr_o,
    output logic [NCH-1:0] evt_data_o,
    output logic           ovf_o
);
    logic [AW-1:0] wcol, trig_col;
    logic          protect;

    lat_wptr #(.DEPTH_MAX(DEPTH_MAX), .AW(AW)) i_wptr (
        .clk        (clk),
        .rst        (rst),
        .cfg_depth_i(cfg_depth_i),
        .cfg_lat_i  (cfg_lat_i),
        .wcol_o     (wcol),
        .trig_col_o (trig_col)
    );

    lat_derand #(.DER_DEPTH(DER_DEPTH), .AW(AW)) i_derand (
        .clk       (clk),
        .rst       (rst),
        .push_i    (trig_i),
        .push_col_i(trig_col),
        .ready_i   (evt_ready_i),
        .wcol_i    (wcol),
        .valid_o   (evt_valid_o),
        .head_col_o(evt_addr_o),
        .protect_o (protect),
        .ovf_o     (ovf_o)
    );

    lat_colmem #(.NCH(NCH), .DEPTH_MAX(DEPTH_MAX), .AW(AW)) i_colmem (
        .clk    (clk),
        .we_i   (!protect),
        .waddr_i(wcol),
        .wdata_i(hit_i),
        .raddr_i(evt_addr_o),
        .rdata_o(evt_data_o)
    );
endmodule

// File: tb/test_lat_pipe_top.sv
module test_lat_pipe_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 128;
    localparam int AW  = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] hit_i = '0;
    logic           trig_i = 1'b0;
    logic [AW-1:0]  cfg_depth_i = 8'd160;
    logic [AW-1:0]  cfg_lat_i = 8'd10;
    logic           evt_valid_o;
    logic           evt_ready_i = 1'b0;
    logic [AW-1:0]  evt_addr_o;
    logic [NCH-1:0] evt_data_o;
    logic           ovf_o;

    int n_chk  = 0;
    int n_fail = 0;
    int k      = 0;
    int dep    = 160;
    int lat    = 10;

    always #(CLK_PERIOD/2) clk = ~clk;

    lat_pipe_top i_lat_pipe_top (
        .clk(clk), .rst(rst), .hit_i(hit_i), .trig_i(trig_i),
        .cfg_depth_i(cfg_depth_i), .cfg_lat_i(cfg_lat_i),
        .evt_valid_o(evt_valid_o), .evt_ready_i(evt_ready_i),
        .evt_addr_o(evt_addr_o), .evt_data_o(evt_data_o), .ovf_o(ovf_o)
    );

    function automatic logic [NCH-1:0] pat(input int c);
        logic [31:0] v;
        v = 32'(c);
        return {v * 32'h9E3779B1, ~(v * 32'h85EBCA6B), v ^ 32'h5A5A0F0F, (v + 32'd7) * 32'h01000193};
    endfunction

    function automatic int col_of(input int c);
        return ((c % dep) + dep) % dep;
    endfunction

    task automatic check(input string req, input string what, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic step(input logic trig, input logic rdy);
        hit_i       = pat(k);
        trig_i      = trig;
        evt_ready_i = rdy;
        @(posedge clk);
        k++;
        @(negedge clk);
        trig_i      = 1'b0;
        evt_ready_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic do_reset(input int d, input int l);
        @(negedge clk);
        rst = 1'b1; dep = d; lat = l;
        cfg_depth_i = AW'(d); cfg_lat_i = AW'(l);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        k = 0;
    endtask

    // expect head event to be the column triggered at cycle tc, then optionally pop it
    task automatic expect_head(input string req, input int tc, input logic do_pop);
        check(req, "valid", NCH'(evt_valid_o), NCH'(1));
        check(req, "addr", NCH'(evt_addr_o), NCH'(col_of(tc - lat)));
        check(req, "data", evt_data_o, pat(tc - lat));
        if (do_pop) step(1'b0, 1'b1);
    endtask

    task automatic t_reset();
        do_reset(160, 10);
        // R1
        check("R1", "valid after reset", NCH'(evt_valid_o), NCH'(0));
        check("R1", "ovf after reset", NCH'(ovf_o), NCH'(0));
    endtask

    task automatic t_basic();
        do_reset(160, 10);
        idle(20);
        step(1'b1, 1'b0);              // trigger at k=20 -> column 10 (R2, R3)
        expect_head("R3", 20, 1'b1);
        check("R5", "empty after pop", NCH'(evt_valid_o), NCH'(0));
    endtask

    task automatic t_zero_lat();
        do_reset(160, 0);
        idle(5);
        step(1'b1, 1'b0);              // R3 latency 0: column 5, written on that edge
        expect_head("R3", 5, 1'b1);
    endtask

    task automatic t_wrap_protect();
        do_reset(20, 15);
        idle(25);
        step(1'b1, 1'b0);              // k=25: W=5 -> column 10 (R4)
        expect_head("R4", 25, 1'b0);
        idle(30);                      // column 10 passed twice while queued (R6)
        check("R6", "queued column kept", evt_data_o, pat(10));
        step(1'b1, 1'b0);              // k=56 -> column 1, refreshed at k=41 (R6)
        step(1'b0, 1'b1);              // pop the first event (R5)
        expect_head("R6", 56, 1'b1);
        check("R5", "empty after two pops", NCH'(evt_valid_o), NCH'(0));
    endtask

    task automatic t_order_hold();
        do_reset(160, 3);
        idle(10);
        step(1'b1, 1'b0);              // k=10
        idle(2);
        step(1'b1, 1'b0);              // k=13
        step(1'b1, 1'b0);              // k=14
        expect_head("R5", 10, 1'b0);
        idle(3);                       // R8: ready low keeps head
        check("R8", "addr held", NCH'(evt_addr_o), NCH'(7));
        check("R8", "data held", evt_data_o, pat(7));
        check("R8", "valid held", NCH'(evt_valid_o), NCH'(1));
        step(1'b0, 1'b1);
        expect_head("R5", 13, 1'b1);
        expect_head("R5", 14, 1'b1);
        check("R5", "empty", NCH'(evt_valid_o), NCH'(0));
    endtask

    task automatic t_overflow();
        do_reset(160, 5);
        idle(10);
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0);   // k=10..25 queued
        check("R7", "no ovf at 16", NCH'(ovf_o), NCH'(0));
        step(1'b1, 1'b1);              // k=26 full: dropped even with pop
        check("R7", "ovf set", NCH'(ovf_o), NCH'(1));
        for (int i = 1; i < 16; i++) expect_head("R7", 10 + i, 1'b1);
        check("R7", "drained, 17th lost", NCH'(evt_valid_o), NCH'(0));
        check("R7", "ovf sticky", NCH'(ovf_o), NCH'(1));
        do_reset(160, 5);
        check("R1", "ovf cleared", NCH'(ovf_o), NCH'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        t_reset();
        t_basic();
        t_zero_lat();
        t_wrap_protect();
        t_order_hold();
        t_overflow();
        report();
    end
endmodule